// File: doc/BRIEF.md
# Interrupt-on-Change GPIO Port Controller

This block manages two general-purpose I/O ports of eight pins each. A host reaches its registers through a plain synchronous bus. The bus has an address, a write enable with write data, and a read enable. Read data comes back one cycle after the read enable. For each pin the block holds a direction, an input inversion, a pull-up request and an output latch. The pad logic takes the pin drive values, output enables and pull-up enables from the block.

Each port watches its enabled pins for change. A pin can be set to trip on any change from its previous synchronized sample. It can instead be set to trip whenever it differs from a programmed reference bit. When a port trips, it records which pins caused the event and takes a snapshot of the port value. It then raises its interrupt line. Flags and snapshot stay frozen until the host reads either the snapshot register or the port value register of that port. Writes to the port value register land in the output latch.

Addresses interleave the two ports: port A sits at even addresses and port B at the next odd address. Register index is the address divided by two: 0 direction, 1 inversion, 2 interrupt enable, 3 reference value, 4 compare mode, 5 spare config (plain storage), 6 pull-up, 7 flags, 8 snapshot, 9 port value, 10 output latch. Pin bits 7:0 belong to port A and bits 15:8 to port B.

Top module: `ioc_gpio_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs, output enables low), all other registers read 0, and both interrupt lines are low.
- R2: A direction bit of 0 drives that pin's output enable high; the pin drive value always equals the output latch bit.
- R3: The port value register (index 9) reads the synchronized pin level XOR the inversion bit.
- R4: A pull-up enable output is high only when its pull-up bit is 1 and the pin is an input.
- R5: With compare mode bit 0, an enabled pin whose synchronized level differs from its sample one clock earlier sets its flag and the port's interrupt line within four clocks of the pin change; pins with interrupt enable 0 never set flags.
- R6: With compare mode bit 1, an enabled pin whose synchronized level differs from its reference bit sets its flag; the condition re-triggers after clearing while it persists.
- R7: The flag register (index 7) is read-only: a 1 bit marks the pin that caused the event, and writes to it have no effect.
- R8: The snapshot register (index 8) loads the port value (after inversion) when a port trips, and it does not change while flags are pending, even when the pins change.
- R9: Reading index 8 or 9 of a port clears that port's flags and drops its interrupt line on the next clock; the other port is unaffected.
- R10: A write to index 9 or 10 updates the output latch; reading index 10 returns the latch, not the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | 8 | Read data, valid the cycle after busRe |
| pinIn | input | 16 | Pin levels, port B in upper byte |
| pinOut | output | 16 | Pin drive values |
| pinOe | output | 16 | Pin output enables |
| pullEn | output | 16 | Pull-up enables |
| irqOut | output | 2 | Interrupt per port, bit 0 for port A |

## Verification
The first pin pattern toggles a pin whose interrupt enable is 0 and then one whose enable is 1. This shows that enable masking works and that change mode compares with the previous sample. A second pattern changes pins back while an event is pending, and the snapshot read shows the frozen value rather than the live one. Reference mode is driven first with a pin equal to its reference bit and then with the reference flipped. A read then clears the event while the mismatch remains, so the test tells a level compare from an edge compare and shows the re-trigger. Reads of one port's registers while the other port is pending confirm that clearing is per port.

// File: rtl/ioc_gpio_pkg.sv
package ioc_gpio_pkg;
  localparam int NPORTS = 2;
  localparam int ADDR_W = 5;
  localparam int NUM_REGS = 11;

  typedef enum logic [3:0] {
    RG_DIR   = 4'd0,
    RG_POL   = 4'd1,
    RG_IEN   = 4'd2,
    RG_DEFV  = 4'd3,
    RG_MODE  = 4'd4,
    RG_CFG   = 4'd5,
    RG_PULL  = 4'd6,
    RG_FLAG  = 4'd7,
    RG_CAP   = 4'd8,
    RG_PORT  = 4'd9,
    RG_LATCH = 4'd10,
    RG_NONE  = 4'd15
  } regSel_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    regSel_e           sel;
    logic              portSel;
    logic [NPORTS-1:0] clr;
  } strobe_t;

  localparam logic [ADDR_W-1:0] ADDR_CAP_A  = 5'h10;
  localparam logic [ADDR_W-1:0] ADDR_PORT_A = 5'h12;
  localparam logic [ADDR_W-1:0] ADDR_DIR_A  = 5'h00;
endpackage

// File: rtl/ioc_gpio_ctl.sv
module ioc_gpio_ctl
  import ioc_gpio_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobe_t           stb
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] regIdx;
  regSel_e          sel;
  logic             writable;
  logic             clearing;

  assign regIdx = busAddr[ADDR_W-1:1];

  always_comb begin
    if (regIdx < IDX_W'(NUM_REGS)) sel = regSel_e'(regIdx);
    else                           sel = RG_NONE;
  end

  assign writable = (sel != RG_FLAG) && (sel != RG_CAP) && (sel != RG_NONE);
  assign clearing = busRe && ((sel == RG_CAP) || (sel == RG_PORT));

  always_comb begin
    stb.wr      = busWe && writable;
    stb.rd      = busRe;
    stb.sel     = sel;
    stb.portSel = busAddr[0];
    for (int p = 0; p < NPORTS; p++)
      stb.clr[p] = clearing && (busAddr[0] == p[0]);
  end
endmodule

// File: rtl/ioc_gpio_dp.sv
module ioc_gpio_dp
  import ioc_gpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  strobe_t                  stb,
  input  logic [PORT_W-1:0]        wdata,
  input  logic [NPORTS*PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0]        rdata,
  output logic [NPORTS*PORT_W-1:0] pinOut,
  output logic [NPORTS*PORT_W-1:0] pinOe,
  output logic [NPORTS*PORT_W-1:0] pullEn,
  output logic [NPORTS-1:0]        irq
);
  logic [PORT_W-1:0] portRd [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PORT_W-1:0] dirR, polR, ienR, defvR, modeR, cfgR, pullR;
    logic [PORT_W-1:0] flagR, capR, latR;
    logic [PORT_W-1:0] syncA, syncB, prevR;
    logic [PORT_W-1:0] portVal, hits;
    logic              wrHere;

    assign wrHere  = stb.wr && (stb.portSel == p[0]);
    assign portVal = syncB ^ polR;
    assign hits    = ienR & ((modeR & (syncB ^ defvR)) | (~modeR & (syncB ^ prevR)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncA <= '0;
        syncB <= '0;
        prevR <= '0;
      end else begin
        syncA <= pinIn[p*PORT_W +: PORT_W];
        syncB <= syncA;
        prevR <= syncB;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dirR  <= '1;
        polR  <= '0;
        ienR  <= '0;
        defvR <= '0;
        modeR <= '0;
        cfgR  <= '0;
        pullR <= '0;
        latR  <= '0;
      end else if (wrHere) begin
        case (stb.sel)
          RG_DIR:            dirR  <= wdata;
          RG_POL:            polR  <= wdata;
          RG_IEN:            ienR  <= wdata;
          RG_DEFV:           defvR <= wdata;
          RG_MODE:           modeR <= wdata;
          RG_CFG:            cfgR  <= wdata;
          RG_PULL:           pullR <= wdata;
          RG_PORT, RG_LATCH: latR  <= wdata;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flagR <= '0;
        capR  <= '0;
      end else if (stb.clr[p]) begin
        flagR <= '0;
      end else if ((flagR == '0) && (hits != '0)) begin
        flagR <= hits;
        capR  <= portVal;
      end
    end

    always_comb begin
      case (stb.sel)
        RG_DIR:   portRd[p] = dirR;
        RG_POL:   portRd[p] = polR;
        RG_IEN:   portRd[p] = ienR;
        RG_DEFV:  portRd[p] = defvR;
        RG_MODE:  portRd[p] = modeR;
        RG_CFG:   portRd[p] = cfgR;
        RG_PULL:  portRd[p] = pullR;
        RG_FLAG:  portRd[p] = flagR;
        RG_CAP:   portRd[p] = capR;
        RG_PORT:  portRd[p] = portVal;
        RG_LATCH: portRd[p] = latR;
        default:  portRd[p] = '0;
      endcase
    end

    assign pinOut[p*PORT_W +: PORT_W] = latR;
    assign pinOe[p*PORT_W +: PORT_W]  = ~dirR;
    assign pullEn[p*PORT_W +: PORT_W] = pullR & dirR;
    assign irq[p]                     = |flagR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (stb.rd) rdata <= portRd[stb.portSel];
  end
endmodule

// File: rtl/ioc_gpio_ctrl.sv
module ioc_gpio_ctrl
  import ioc_gpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [PORT_W-1:0]        busWdata,
  input  logic                     busRe,
  output logic [PORT_W-1:0]        busRdata,
  input  logic [NPORTS*PORT_W-1:0] pinIn,
  output logic [NPORTS*PORT_W-1:0] pinOut,
  output logic [NPORTS*PORT_W-1:0] pinOe,
  output logic [NPORTS*PORT_W-1:0] pullEn,
  output logic [NPORTS-1:0]        irqOut
);
  strobe_t stb;

  ioc_gpio_ctl ctl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .stb     (stb)
  );

  ioc_gpio_dp #(.PORT_W(PORT_W)) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .rdata  (busRdata),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .pullEn (pullEn),
    .irq    (irqOut)
  );
endmodule

// File: rtl/ioc_gpio_chk.sv
module ioc_gpio_chk
  import ioc_gpio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        busAddr,
  input logic                     busWe,
  input logic [PORT_W-1:0]        busWdata,
  input logic                     busRe,
  input logic [NPORTS*PORT_W-1:0] pinOut,
  input logic [NPORTS*PORT_W-1:0] pinOe,
  input logic [NPORTS*PORT_W-1:0] pullEn,
  input logic [NPORTS-1:0]        irqOut
);
  logic clrA;
  assign clrA = busRe && ((busAddr == ADDR_CAP_A) || (busAddr == ADDR_PORT_A));

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_DIR_A) |=> (pinOe[PORT_W-1:0] == ~$past(busWdata)));

  p_port_wr_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == ADDR_PORT_A) |=> (pinOut[PORT_W-1:0] == $past(busWdata)));

  p_pull_input_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pullEn & pinOe) == '0));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clrA |=> !irqOut[0]);

  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut[0] && !clrA) |=> irqOut[0]);
endmodule

bind ioc_gpio_ctrl ioc_gpio_chk #(.PORT_W(PORT_W)) chk_i (.*);

// File: tb/ioc_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module ioc_gpio_ctrl_tb_top;
  localparam int W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic        busRe = 1'b0;
  logic [7:0]  busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe, pullEn;
  logic [1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ [$];
  string      tagQ [$];

  always #4 clk = ~clk;

  ioc_gpio_ctrl #(.PORT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compares read data one edge after the read strobe
  always @(posedge clk) begin
    logic rdWas;
    rdWas = busRe;
    #2;
    if (rdWas && rst_n) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", busRdata);
      end else begin
        check(tagQ.pop_front(), {8'h00, busRdata}, {8'h00, expQ.pop_front()});
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", {14'h0, irqOut}, 16'h0);
    check("R1 oe", pinOe, 16'h0);
    check("R1 pull", pullEn, 16'h0);
    check("R1 out", pinOut, 16'h0);
    rdReg(5'h00, 8'hFF, "R1 dirA");
    rdReg(5'h01, 8'hFF, "R1 dirB");
    rdReg(5'h15, 8'h00, "R1 latchB");
    rdReg(5'h04, 8'h00, "R1 ienA");

    // R2 direction and drive
    wrReg(5'h00, 8'h0F);
    check("R2 oe", pinOe, 16'h00F0);
    wrReg(5'h14, 8'hA5);
    check("R2 out", pinOut, 16'h00A5);

    // R10 latch read vs pins
    rdReg(5'h14, 8'hA5, "R10 latchA");
    wrReg(5'h13, 8'h3C);
    rdReg(5'h15, 8'h3C, "R10 latchB via port write");
    check("R10 outB", pinOut, 16'h3CA5);

    // R4 pull-up only on inputs
    wrReg(5'h0C, 8'hFF);
    check("R4 pull", pullEn, 16'h000F);
    wrReg(5'h00, 8'hFF);
    check("R4 pull all in", pullEn, 16'h00FF);

    // R3 polarity
    @(negedge clk); pinIn = 16'h815A;
    idle(4);
    wrReg(5'h02, 8'hF0);
    rdReg(5'h12, 8'hAA, "R3 inverted A");
    rdReg(5'h13, 8'h81, "R3 plain B");
    wrReg(5'h02, 8'h00);

    // R5 change mode, masking
    wrReg(5'h04, 8'h01);
    @(negedge clk); pinIn = 16'h8158;
    idle(5);
    check("R5 masked pin", {14'h0, irqOut}, 16'h0);
    @(negedge clk); pinIn = 16'h8159;
    idle(4);
    check("R5 enabled change", {14'h0, irqOut}, 16'h1);
    rdReg(5'h0E, 8'h01, "R7 flag bit");
    wrReg(5'h0E, 8'h00);
    rdReg(5'h0E, 8'h01, "R7 flag write ignored");

    // R8 freeze while pending
    @(negedge clk); pinIn = 16'h8158;
    idle(5);
    check("R8 still pending", {14'h0, irqOut}, 16'h1);
    rdReg(5'h0F, 8'h00, "R9 other port flags");
    rdReg(5'h10, 8'h59, "R8 frozen capture");
    check("R9 cleared A", {14'h0, irqOut}, 16'h0);
    idle(3);
    check("R9 stays clear", {14'h0, irqOut}, 16'h0);
    wrReg(5'h0E, 8'hFF);
    check("R7 write no irq", {14'h0, irqOut}, 16'h0);
    rdReg(5'h0E, 8'h00, "R7 flags zero");

    // R6 reference compare on port B
    wrReg(5'h07, 8'h81);
    wrReg(5'h09, 8'h80);
    wrReg(5'h05, 8'h80);
    idle(3);
    check("R6 equal no irq", {14'h0, irqOut}, 16'h0);
    wrReg(5'h07, 8'h01);
    idle(2);
    check("R6 mismatch irq", {14'h0, irqOut}, 16'h2);
    rdReg(5'h0F, 8'h80, "R6 flag B");
    rdReg(5'h12, 8'h58, "R9 port A read");
    check("R9 B unaffected", {14'h0, irqOut}, 16'h2);
    rdReg(5'h13, 8'h81, "R6 port B read");
    idle(2);
    check("R6 retrigger", {14'h0, irqOut}, 16'h2);
    rdReg(5'h11, 8'h81, "R8 capture B");
    wrReg(5'h07, 8'h81);
    rdReg(5'h11, 8'h81, "R9 clear B");
    idle(3);
    check("R9 B clear", {14'h0, irqOut}, 16'h0);

    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule